// File: doc/BRIEF.md
# Row-Buffered Dynamic Memory Array

This block models a one-bit-wide dynamic memory organised as a square grid of storage rows. Every access goes through a row buffer, which is a bank of one-bit column latches that holds a full copy of one row. A single narrow address bus is shared in time. The row address is presented together with the row strobe. The column address follows later with the column strobe. Opening a row is a destructive sense: the cells of the chosen row lose their contents, and the row buffer holds the only copy until it is written back.

A host raises `ras` with a row address to open that row. While `ras` stays high it issues column reads and writes with `cas`. It lowers `ras` to close the row, and closing writes the whole buffer back into the grid. A refresh command takes a row address while no row is open. It senses that row and restores it in two steps.

The grid has `2**ADDR_W` rows and `2**ADDR_W` columns. The default of 3 gives an 8×8 instance for short runs. A value of 11 gives the full 2048×2048 organisation.

Top module: `dram_rowbuf_top`

## Requirements
- R1: After reset, `ready` is 1 and `valid` is 0, and no row is open.
- R2: In the idle state, `ras`=1 with `addr` holding a row number opens that row. `ready` is 0 for exactly one cycle while the row is copied into the buffer, then returns to 1. A host that uses a flat address places the row number in its upper `ADDR_W` bits and the column number in its lower `ADDR_W` bits, so flat address 101011 on an 8×8 grid selects row 5, column 3.
- R3: With a row open, `cas`=1 and `we`=0 with `addr` holding a column starts a read. On the next cycle `valid` is 1 and `dout` carries that column's buffered bit. `valid` is 0 in every other cycle.
- R4: With a row open, `cas`=1 and `we`=1 stores `din` into the selected column latch only. Later reads of the open row return the new bit at that column and the old bits at every other column.
- R5: A read that hits the open row completes one cycle after `cas`. A read of a closed row takes three cycles from the raising of `ras` to `valid`.
- R6: Lowering `ras` while a row is open takes one busy cycle, in which the whole buffer is written back to its row, and then returns to idle. Every location keeps the last value written to it across any sequence of row changes.
- R7: In the idle state, `refresh`=1 with `addr` holding a row keeps `ready` at 0 for two cycles while that row is sensed and restored. The stored contents of the row are unchanged afterwards.
- R8: `cas` in the idle state and `refresh` while a row is open are ignored. Neither changes `ready`, `valid` or any stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Shared row/column address |
| ras | input | 1 | Row strobe: high opens a row and keeps it open, low closes it |
| cas | input | 1 | Column strobe: starts a column access in an open row |
| we | input | 1 | Write select for a column access |
| din | input | 1 | Write data bit |
| refresh | input | 1 | Refresh request for the row on `addr` (idle only) |
| dout | output | 1 | Read data bit, meaningful while `valid` is 1 |
| ready | output | 1 | Block accepts a command this cycle |
| valid | output | 1 | Read data present on `dout` |

## Verification
The hardest situation to reach from the ports is a lost write-back. Opening a row wipes its cells, so a missing or misdirected restore is invisible while the row stays open, and it shows only after that row is closed, another row is opened, and the first row is opened again. The stimulus first fills the whole grid row by row. It then reads every row back after the others have been opened and closed, modifies one bit in an open row and revisits that row after a detour, and refreshes every row before a final full read. Commands that must be ignored are injected in idle and open states, each followed by reads of the locations they could have disturbed.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACT     = 3'd1,
    ST_OPEN    = 3'd2,
    ST_READ    = 3'd3,
    ST_WRITE   = 3'd4,
    ST_PRE     = 3'd5,
    ST_REF     = 3'd6,
    ST_RESTORE = 3'd7
  } dram_state_e;

endpackage

// File: rtl/dram_row_dec.sv
module dram_row_dec #(
  parameter int ADDR_W = 3,
  localparam int ROWS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] row,
  output logic [ROWS-1:0]   row_sel
);

  // one select line per row, built by a comparator per line
  for (genvar g = 0; g < ROWS; g++) begin : g_line
    assign row_sel[g] = (row == ADDR_W'(g));
  end

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ADDR_W = 3,
  localparam int ROWS = 1 << ADDR_W,
  localparam int COLS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] row,
  input  logic              sense_en,
  input  logic              restore_en,
  input  logic [COLS-1:0]   wdata,
  output logic [COLS-1:0]   rdata
);

  logic [ROWS-1:0] row_sel;
  logic [COLS-1:0] mem [ROWS];

  dram_row_dec #(.ADDR_W(ADDR_W)) dec_i (
    .row     (row),
    .row_sel (row_sel)
  );

  // storage grid: sensing drains the selected row, restoring refills it
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (row_sel[r]) begin
        if (restore_en) begin
          mem[r] <= wdata;
        end else if (sense_en) begin
          mem[r] <= '0;
        end
      end
    end
  end

  assign rdata = mem[row];

  // checker state: a sensed row awaits its restore
  logic pending;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (sense_en) begin
      pending <= 1'b1;
    end else if (restore_en) begin
      pending <= 1'b0;
    end
  end

  // R6: no second row is sensed before the first has been restored
  a_r6_no_sense_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |-> !pending);
  // R6: every restore belongs to an earlier sense
  a_r6_restore_has_sense: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |-> pending);
  // R2: a grid operation touches exactly one row
  a_r2_one_row_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_en || restore_en) |-> ($countones(row_sel) == 1));

endmodule

// File: rtl/dram_row_latch.sv
module dram_row_latch #(
  parameter int ADDR_W = 3,
  localparam int COLS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [COLS-1:0]   load_row,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] col,
  input  logic              wr_bit,
  output logic [COLS-1:0]   row_q,
  output logic              bit_out
);

  logic [COLS-1:0] row_d;

  always_comb begin
    row_d = row_q;
    if (load_en) begin
      row_d = load_row;
    end else if (wr_en) begin
      row_d[col] = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (load_en || wr_en) begin
      row_q <= row_d;
    end
  end

  // column multiplexor
  assign bit_out = row_q[col];

  // R4: a column write changes at most one latch
  a_r4_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load_en) |=> ($countones(row_q ^ $past(row_q)) <= 1));
  // R4: the written bit lands in the addressed latch
  a_r4_bit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load_en) |=> (row_q[$past(col)] == $past(wr_bit)));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras,
  input  logic              cas,
  input  logic              we,
  input  logic              din,
  input  logic              refresh,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output logic              din_q,
  output logic              sense_en,
  output logic              restore_en,
  output logic              wr_en,
  output logic              ready,
  output logic              valid
);

  dram_state_e state_q, state_d;
  logic        row_ld, col_ld;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ras)          state_d = ST_ACT;
        else if (refresh) state_d = ST_REF;
      end
      ST_ACT:  state_d = ST_OPEN;
      ST_OPEN: begin
        if (!ras)         state_d = ST_PRE;
        else if (cas)     state_d = we ? ST_WRITE : ST_READ;
      end
      ST_READ, ST_WRITE: state_d = ST_OPEN;
      ST_PRE:            state_d = ST_IDLE;
      ST_REF:            state_d = ST_RESTORE;
      ST_RESTORE:        state_d = ST_IDLE;
      default:           state_d = ST_IDLE;
    endcase
  end

  assign row_ld = (state_q == ST_IDLE) && (ras || refresh);
  assign col_ld = (state_q == ST_OPEN) && ras && cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_ld) begin
      row_q <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      din_q <= 1'b0;
    end else if (col_ld) begin
      col_q <= addr;
      din_q <= din;
    end
  end

  assign sense_en   = (state_q == ST_ACT) || (state_q == ST_REF);
  assign restore_en = (state_q == ST_PRE) || (state_q == ST_RESTORE);
  assign wr_en      = (state_q == ST_WRITE);
  assign ready      = (state_q == ST_IDLE) || (state_q == ST_OPEN);
  assign valid      = (state_q == ST_READ);

  // R3: read data only appears right after a column read strobe
  a_r3_valid_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(ras && cas && !we));
  // R2: activation lasts exactly one cycle
  a_r2_act_then_open: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACT) |=> (state_q == ST_OPEN));
  // R8: column strobe alone leaves the idle state untouched
  a_r8_idle_cas_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !ras && !refresh) |=> (state_q == ST_IDLE));
  // R7: refresh holds off commands for two cycles
  a_r7_refresh_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REF) |=> (!ready ##1 ready));

endmodule

// File: rtl/dram_rowbuf_top.sv
module dram_rowbuf_top #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras,
  input  logic              cas,
  input  logic              we,
  input  logic              din,
  input  logic              refresh,
  output logic              dout,
  output logic              ready,
  output logic              valid
);

  localparam int COLS = 1 << ADDR_W;

  logic [ADDR_W-1:0] row_q, col_q;
  logic              din_q, sense_en, restore_en, wr_en;
  logic [COLS-1:0]   grid_row, buf_row;

  dram_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .ras        (ras),
    .cas        (cas),
    .we         (we),
    .din        (din),
    .refresh    (refresh),
    .row_q      (row_q),
    .col_q      (col_q),
    .din_q      (din_q),
    .sense_en   (sense_en),
    .restore_en (restore_en),
    .wr_en      (wr_en),
    .ready      (ready),
    .valid      (valid)
  );

  dram_cell_array #(.ADDR_W(ADDR_W)) grid_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .row        (row_q),
    .sense_en   (sense_en),
    .restore_en (restore_en),
    .wdata      (buf_row),
    .rdata      (grid_row)
  );

  dram_row_latch #(.ADDR_W(ADDR_W)) latch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (sense_en),
    .load_row (grid_row),
    .wr_en    (wr_en),
    .col      (col_q),
    .wr_bit   (din_q),
    .row_q    (buf_row),
    .bit_out  (dout)
  );

endmodule

// File: tb/dram_rowbuf_top_tb.sv
module dram_rowbuf_top_tb_top;

  localparam int AW = 3;
  localparam int N = 1 << AW;
  localparam time CLK_PERIOD = 10ns;

  logic clk, rst_n;
  logic [AW-1:0] addr;
  logic ras, cas, we, din, refresh;
  logic dout, ready, valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit refm [N*N];

  dram_rowbuf_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras(ras), .cas(cas), .we(we),
    .din(din), .refresh(refresh), .dout(dout), .ready(ready), .valid(valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit pat(int r, int c);
    return bit'((((r * 7 + c * 3) >> 2) ^ (r & c)) & 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_row(int r);
    ras = 1'b1; addr = AW'(r);
    @(negedge clk);
    chk(ready == 1'b0, "R2 busy during activate", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R2 ready after activate", ready, 1);
  endtask

  task automatic close_row();
    ras = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R6 busy during write-back", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R6 idle after write-back", ready, 1);
  endtask

  task automatic rd(int r, int c, string req);
    cas = 1'b1; we = 1'b0; addr = AW'(c);
    @(negedge clk);
    cas = 1'b0;
    chk(valid == 1'b1, req, valid, 1);
    chk(dout == refm[r*N+c], req, dout, refm[r*N+c]);
    @(negedge clk);
    chk(valid == 1'b0, "R3 valid drops", valid, 0);
  endtask

  task automatic wr(int r, int c, bit d);
    cas = 1'b1; we = 1'b1; addr = AW'(c); din = d;
    @(negedge clk);
    cas = 1'b0; we = 1'b0;
    chk(valid == 1'b0, "R3 no valid on write", valid, 0);
    refm[r*N+c] = d;
    @(negedge clk);
  endtask

  task automatic do_refresh(int r);
    refresh = 1'b1; addr = AW'(r);
    @(negedge clk);
    refresh = 1'b0;
    chk(ready == 1'b0, "R7 busy cycle 1", ready, 0);
    @(negedge clk);
    chk(ready == 1'b0, "R7 busy cycle 2", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R7 idle after refresh", ready, 1);
  endtask

  task automatic read_all(string req);
    for (int r = 0; r < N; r++) begin
      open_row(r);
      for (int c = 0; c < N; c++) rd(r, c, req);
      close_row();
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; addr = '0; ras = 0; cas = 0; we = 0; din = 0; refresh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(valid == 1'b0, "R1 valid after reset", valid, 0);

    // fill the grid, row by row (R4)
    for (int r = 0; r < N; r++) begin
      open_row(r);
      for (int c = 0; c < N; c++) wr(r, c, pat(r, c));
      close_row();
    end
    // R6: every row read back after all others were opened and closed
    read_all("R6 data after row changes");

    // R2: flat address 101011 -> row 5, column 3
    open_row(6'b101011 >> AW);
    rd(5, 3, "R2 flat address split");
    close_row();

    // R5: miss latency from ras, hit latency from cas
    ras = 1'b1; addr = AW'(2); n = 0;
    do begin @(negedge clk); n++; end while (!ready && n < 10);
    cas = 1'b1; we = 1'b0; addr = AW'(6);
    @(negedge clk); n++;
    cas = 1'b0;
    chk(valid == 1'b1 && n == 3, "R5 miss latency", n, 3);
    chk(dout == refm[2*N+6], "R5 miss data", dout, refm[2*N+6]);
    @(negedge clk);
    cas = 1'b1; addr = AW'(1);
    @(negedge clk);
    cas = 1'b0;
    chk(valid == 1'b1, "R5 hit latency one cycle", valid, 1);
    chk(dout == refm[2*N+1], "R5 hit data", dout, refm[2*N+1]);
    @(negedge clk);

    // R4: one bit flipped, neighbours unchanged, persists after detour
    wr(2, 4, !refm[2*N+4]);
    for (int c = 0; c < N; c++) rd(2, c, "R4 single column write");
    close_row();
    open_row(7); rd(7, 0, "R6 detour row"); close_row();
    open_row(2);
    for (int c = 0; c < N; c++) rd(2, c, "R6 write survives reopen");

    // R8: refresh while a row is open is ignored
    refresh = 1'b1; addr = AW'(5);
    @(negedge clk);
    refresh = 1'b0;
    chk(ready == 1'b1 && valid == 1'b0, "R8 refresh ignored when open", ready, 1);
    rd(2, 4, "R8 open row intact");
    close_row();

    // R8: cas with write in idle is ignored
    cas = 1'b1; we = 1'b1; din = !refm[3*N+3]; addr = AW'(3);
    @(negedge clk);
    cas = 1'b0; we = 1'b0;
    chk(ready == 1'b1 && valid == 1'b0, "R8 idle cas ignored", ready, 1);
    open_row(3);
    for (int c = 0; c < N; c++) rd(3, c, "R8 idle cas left data");
    close_row();

    // R7: refresh every row, then read the whole grid
    for (int r = 0; r < N; r++) do_refresh(r);
    read_all("R7 data after refresh");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule